// File: doc/BRIEF.md
# Debug Register Access Lock with Challenge-Response Unlock

This block stands between a debug transport and the register file of a debug module. Every register request (valid, write flag, address, write word) passes through it. The block decides whether a write may reach the registers behind it. Until a debugger has shown that it knows a secret constant, only two writes get through: the unlock register and the control register. Every other write is refused, and the refusal is flagged in the same cycle. Reads are never blocked.

To unlock, the debugger reads a 32-bit challenge from the unlock register. It then writes back that challenge plus the secret, with the sum taken modulo 2^32. A correct answer opens the gate. A wrong answer closes the gate and replaces the challenge with a fresh value from a free-running 32-bit LFSR. Because the expected answer is registered together with the challenge, no adder sits in the compare path. A parameter can turn the lock off entirely. In that case the gate starts open and writes to the unlock register are accepted but change nothing.

The block also owns a small control register. It holds an activate bit and the halt and resume request bits. An activate transition from 0 to 1 produces a one-cycle module reset pulse.

Top module: `dbg_auth_gate`

## Requirements
- R1: After reset, `authenticated` equals the inverse of `REQUIRE_AUTH`, the challenge equals `LFSR_SEED`, and `dm_active`, `halt_req`, `resume_req` and `mod_rst` are 0.
- R2: While `authenticated` is 0, a write to any address other than `ADDR_AUTH` or `ADDR_CTRL` raises `wr_err` in the same cycle and leaves `fwd_we` at 0. While `authenticated` is 1, a write to any address other than the three local ones raises `fwd_we` and leaves `wr_err` at 0.
- R3: A read returns a value chosen by address:
  - `ADDR_AUTH` returns the current challenge.
  - `ADDR_STAT` returns bit0 = `authenticated` and bit1 = `REQUIRE_AUTH`, with the other bits 0.
  - `ADDR_CTRL` returns bit0 = active, bit1 = halt request and bit2 = resume request.
  - Any other address returns `fwd_rdata` unchanged, in the same cycle.
- R4: With `REQUIRE_AUTH` = 1, writing challenge + `SECRET` (mod 2^32) to `ADDR_AUTH` sets `authenticated` from the next cycle on.
- R5: With `REQUIRE_AUTH` = 1, writing any other value to `ADDR_AUTH` clears `authenticated` from the next cycle on. It also loads the challenge with the LFSR state of the cycle in which the write occurs. The challenge changes at no other time.
- R6: With `REQUIRE_AUTH` = 0, writes to `ADDR_AUTH` raise no `wr_err`, leave `authenticated` at 1 and leave the challenge unchanged.
- R7: A control write made while `authenticated` is 0 updates only the active bit (write bit0). Halt and resume keep their values unless the write raises active from 0 to 1, in which case both are cleared.
- R8: A control write that takes active from 0 to 1 produces `mod_rst` = 1 for exactly the following cycle.
- R9: The LFSR holds `LFSR_SEED` during reset. On every clock edge out of reset it shifts right by one; if the bit shifted out was 1, the result is XORed with 32'h80200003. It is never zero.
- R10: A control write made while `authenticated` is 1 loads active = bit0, halt = bit0 AND bit1, and resume = bit0 AND bit2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | 32 | Write word |
| rd_data | output | 32 | Read word, combinational |
| wr_err | output | 1 | Write refused by the lock, combinational |
| fwd_we | output | 1 | Write enable toward the register file behind the gate |
| fwd_addr | output | ADDR_W | Address toward the register file |
| fwd_wdata | output | 32 | Write word toward the register file |
| fwd_rdata | input | 32 | Read word from the register file |
| authenticated | output | 1 | Gate open |
| dm_active | output | 1 | Activate bit of the control register |
| halt_req | output | 1 | Halt request bit |
| resume_req | output | 1 | Resume request bit |
| mod_rst | output | 1 | One-cycle module reset pulse |

## Verification
Some rules are checked by assertions on every cycle:
- a refused write never reaches the register file and only happens while locked;
- the challenge moves only on a failed answer, and then to the LFSR state;
- a correct answer opens the gate and a wrong one closes it;
- a locked control write does not move halt or resume;
- an activate edge yields one reset pulse;
- the LFSR never reaches zero.

Only the bench scenarios can show that the unlock word really is challenge plus secret, and that a freshly drawn challenge, read back and answered, unlocks the gate. They also cover the read multiplexing of each address and the open configuration, which a second instance exercises.

// File: rtl/dag_pkg.sv
package dag_pkg;

  localparam int unsigned WORD_W = 32;
  localparam logic [WORD_W-1:0] LFSR_TAPS = 32'h80200003;

  typedef struct packed {
    logic resume;
    logic halt;
    logic active;
  } ctrl_t;

  typedef enum logic [1:0] {
    SEL_OTHER,
    SEL_CTRL,
    SEL_STAT,
    SEL_AUTH
  } sel_e;

  // One Galois step of the challenge generator.
  function automatic logic [WORD_W-1:0] lfsr_next(input logic [WORD_W-1:0] s);
    return {1'b0, s[WORD_W-1:1]} ^ (s[0] ? LFSR_TAPS : '0);
  endfunction

  // Expected answer for a given challenge (wraps modulo 2^32).
  function automatic logic [WORD_W-1:0] unlock_word(input logic [WORD_W-1:0] chal,
                                                     input logic [WORD_W-1:0] key);
    return chal + key;
  endfunction

  // Control register update, authenticated case.
  function automatic ctrl_t ctrl_open_load(input logic [2:0] w);
    ctrl_t c;
    c.active = w[0];
    c.halt   = w[0] & w[1];
    c.resume = w[0] & w[2];
    return c;
  endfunction

endpackage

// File: rtl/dag_lfsr.sv
module dag_lfsr
  import dag_pkg::*;
#(
  parameter logic [WORD_W-1:0] SEED = 32'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [WORD_W-1:0] state
);

  logic [WORD_W-1:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= lfsr_next(state_q);
  end

  assign state = state_q;

  // R9: the generator never locks up at zero
  a_r9_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

endmodule

// File: rtl/dag_auth.sv
module dag_auth
  import dag_pkg::*;
#(
  parameter bit                REQUIRE_AUTH = 1'b1,
  parameter logic [WORD_W-1:0] SECRET       = 32'h0,
  parameter logic [WORD_W-1:0] SEED         = 32'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] lfsr_val,
  input  logic              auth_wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] challenge,
  output logic              authed,
  output logic              fail_ev,
  output logic              pass_ev
);

  logic [WORD_W-1:0] challenge_q;
  logic [WORD_W-1:0] expect_q;
  logic              authed_q;
  logic              answer_ok;

  assign answer_ok = (wdata == expect_q);
  assign pass_ev   = REQUIRE_AUTH && auth_wr &&  answer_ok;
  assign fail_ev   = REQUIRE_AUTH && auth_wr && !answer_ok;

  // Challenge and expected answer are loaded together, so the
  // compare above sees only a register, never the adder.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      challenge_q <= SEED;
      expect_q    <= unlock_word(SEED, SECRET);
      authed_q    <= !REQUIRE_AUTH;
    end else if (pass_ev) begin
      authed_q    <= 1'b1;
    end else if (fail_ev) begin
      authed_q    <= 1'b0;
      challenge_q <= lfsr_val;
      expect_q    <= unlock_word(lfsr_val, SECRET);
    end
  end

  assign challenge = challenge_q;
  assign authed    = authed_q;

  // R1: reset state of the lock
  a_r1_reset_lock: assert property (@(posedge clk)
    !rst_n |=> (authed_q == !REQUIRE_AUTH) && (challenge_q == SEED));

  // R4: a correct answer opens the gate
  a_r4_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    pass_ev |=> authed_q);

  // R5: a wrong answer closes the gate and draws from the generator
  a_r5_relock: assert property (@(posedge clk) disable iff (!rst_n)
    fail_ev |=> !authed_q && (challenge_q == $past(lfsr_val)));

  // R5: the challenge moves only on a failed answer
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fail_ev |=> $stable(challenge_q));

  // R6: with the lock disabled, unlock writes change nothing
  a_r6_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!REQUIRE_AUTH && auth_wr) |=> $stable(authed_q) && $stable(challenge_q));

endmodule

// File: rtl/dag_ctrl.sv
module dag_ctrl
  import dag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [2:0] wbits,
  input  logic       authed,
  output ctrl_t      ctrl,
  output logic       rise_ev,
  output logic       mod_rst
);

  ctrl_t ctrl_q;
  logic  mod_rst_q;

  assign rise_ev = ctrl_wr && !ctrl_q.active && wbits[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      mod_rst_q <= 1'b0;
    end else begin
      mod_rst_q <= rise_ev;
      if (ctrl_wr) begin
        if (authed) begin
          ctrl_q <= ctrl_open_load(wbits);
        end else begin
          ctrl_q.active <= wbits[0];
          if (rise_ev) begin
            ctrl_q.halt   <= 1'b0;
            ctrl_q.resume <= 1'b0;
          end
        end
      end
    end
  end

  assign ctrl    = ctrl_q;
  assign mod_rst = mod_rst_q;

  // R7: a locked control write leaves the request bits alone
  a_r7_locked_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !authed && !rise_ev) |=> $stable(ctrl_q.halt) && $stable(ctrl_q.resume));

  // R8: an activate edge gives a reset pulse next cycle
  a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> mod_rst_q);

  // R8: the pulse lasts a single cycle
  a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
    mod_rst_q |=> !mod_rst_q);

endmodule

// File: rtl/dbg_auth_gate.sv
module dbg_auth_gate
  import dag_pkg::*;
#(
  parameter int unsigned        ADDR_W       = 7,
  parameter bit                 REQUIRE_AUTH = 1'b1,
  parameter logic [WORD_W-1:0]  SECRET       = 32'h5EC7_0A11,
  parameter logic [WORD_W-1:0]  LFSR_SEED    = 32'hACE1_2469,
  parameter logic [ADDR_W-1:0]  ADDR_CTRL    = 7'h10,
  parameter logic [ADDR_W-1:0]  ADDR_STAT    = 7'h11,
  parameter logic [ADDR_W-1:0]  ADDR_AUTH    = 7'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rd_data,
  output logic              wr_err,
  output logic              fwd_we,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [31:0]       fwd_wdata,
  input  logic [31:0]       fwd_rdata,
  output logic              authenticated,
  output logic              dm_active,
  output logic              halt_req,
  output logic              resume_req,
  output logic              mod_rst
);

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  sel_e              sel;
  logic              wr_any;
  logic              wr_pass;
  logic              auth_wr;
  logic              ctrl_wr;
  logic [WORD_W-1:0] lfsr_val;
  logic [WORD_W-1:0] challenge;
  logic              authed;
  logic              fail_ev;
  logic              pass_ev;
  logic              rise_ev;
  ctrl_t             ctrl;

  // Address decode
  always_comb begin
    if      (req_addr == ADDR_AUTH) sel = SEL_AUTH;
    else if (req_addr == ADDR_CTRL) sel = SEL_CTRL;
    else if (req_addr == ADDR_STAT) sel = SEL_STAT;
    else                            sel = SEL_OTHER;
  end

  // Locked writes get through only to the unlock and control registers.
  assign wr_any  = req_valid && req_write;
  assign wr_pass = authed || (sel == SEL_AUTH) || (sel == SEL_CTRL);
  assign wr_err  = wr_any && !wr_pass;
  assign auth_wr = wr_any && (sel == SEL_AUTH);
  assign ctrl_wr = wr_any && (sel == SEL_CTRL);
  assign fwd_we  = wr_any && wr_pass && (sel == SEL_OTHER);

  assign fwd_addr  = req_addr;
  assign fwd_wdata = req_wdata;

  dag_lfsr #(
    .SEED (LFSR_SEED)
  ) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .state (lfsr_val)
  );

  dag_auth #(
    .REQUIRE_AUTH (REQUIRE_AUTH),
    .SECRET       (SECRET),
    .SEED         (LFSR_SEED)
  ) u_auth (
    .clk       (clk),
    .rst_n     (rst_n),
    .lfsr_val  (lfsr_val),
    .auth_wr   (auth_wr),
    .wdata     (req_wdata),
    .challenge (challenge),
    .authed    (authed),
    .fail_ev   (fail_ev),
    .pass_ev   (pass_ev)
  );

  dag_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_wr (ctrl_wr),
    .wbits   (req_wdata[2:0]),
    .authed  (authed),
    .ctrl    (ctrl),
    .rise_ev (rise_ev),
    .mod_rst (mod_rst)
  );

  // Read multiplexer
  always_comb begin
    unique case (sel)
      SEL_AUTH: rd_data = challenge;
      SEL_STAT: rd_data = {30'd0, REQUIRE_AUTH, authed};
      SEL_CTRL: rd_data = {{(32-CTRL_W){1'b0}}, ctrl};
      default:  rd_data = fwd_rdata;
    endcase
  end

  assign authenticated = authed;
  assign dm_active     = ctrl.active;
  assign halt_req      = ctrl.halt;
  assign resume_req    = ctrl.resume;

  // R2: a refused write never reaches the register file, and only happens while locked
  a_r2_reject: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> !fwd_we && !authenticated);

  // R4/R5: pass and fail are never signalled together
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_ev && fail_ev));

endmodule

// File: tb/dbg_auth_gate_test.sv
module dbg_auth_gate_test;

  localparam int          AW      = 7;
  localparam logic [31:0] KEY     = 32'hF00D_BEEF;
  localparam logic [31:0] SEED    = 32'h1357_9BDF;
  localparam logic [6:0]  A_CTRL  = 7'h10;
  localparam logic [6:0]  A_STAT  = 7'h11;
  localparam logic [6:0]  A_AUTH  = 7'h30;
  localparam logic [6:0]  A_OTHER = 7'h04;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [31:0]   fwd_rdata = 32'hCAFE_1234;

  logic [31:0]   rd_data, rd_open;
  logic          wr_err, wr_err_open, fwd_we, fwd_we_open;
  logic [AW-1:0] fwd_addr, fwd_addr_open;
  logic [31:0]   fwd_wdata, fwd_wdata_open;
  logic          authenticated, auth_open;
  logic          dm_active, halt_req, resume_req, mod_rst;
  logic          act_open, halt_open, res_open, mrst_open;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dbg_auth_gate #(
    .ADDR_W(AW), .REQUIRE_AUTH(1'b1), .SECRET(KEY), .LFSR_SEED(SEED),
    .ADDR_CTRL(A_CTRL), .ADDR_STAT(A_STAT), .ADDR_AUTH(A_AUTH)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data), .wr_err(wr_err),
    .fwd_we(fwd_we), .fwd_addr(fwd_addr), .fwd_wdata(fwd_wdata), .fwd_rdata(fwd_rdata),
    .authenticated(authenticated), .dm_active(dm_active), .halt_req(halt_req),
    .resume_req(resume_req), .mod_rst(mod_rst)
  );

  dbg_auth_gate #(
    .ADDR_W(AW), .REQUIRE_AUTH(1'b0), .SECRET(KEY), .LFSR_SEED(SEED),
    .ADDR_CTRL(A_CTRL), .ADDR_STAT(A_STAT), .ADDR_AUTH(A_AUTH)
  ) uut_open (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_open), .wr_err(wr_err_open),
    .fwd_we(fwd_we_open), .fwd_addr(fwd_addr_open), .fwd_wdata(fwd_wdata_open),
    .fwd_rdata(fwd_rdata), .authenticated(auth_open), .dm_active(act_open),
    .halt_req(halt_open), .resume_req(res_open), .mod_rst(mrst_open)
  );

  // ---------------- reference model ----------------
  longint unsigned m_gen, m_chal;
  bit m_auth, m_act, m_halt, m_res, m_pulse;

  function automatic longint unsigned gen_step(input longint unsigned s);
    longint unsigned n;
    n = s / 2;
    if ((s % 2) == 1) n = n ^ 64'h8020_0003;
    return n;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gen = SEED; m_chal = SEED; m_auth = 1'b0;
      m_act = 1'b0; m_halt = 1'b0; m_res = 1'b0; m_pulse = 1'b0;
    end else begin
      bit was_auth;
      bit rise;
      was_auth = m_auth;
      rise = 1'b0;
      if (req_valid && req_write && req_addr == A_AUTH) begin
        if (longint'(req_wdata) == ((m_chal + KEY) % 64'h1_0000_0000)) m_auth = 1'b1;
        else begin m_auth = 1'b0; m_chal = m_gen; end
      end
      if (req_valid && req_write && req_addr == A_CTRL) begin
        rise = !m_act && req_wdata[0];
        m_act = req_wdata[0];
        if (was_auth) begin
          m_halt = req_wdata[0] && req_wdata[1];
          m_res  = req_wdata[0] && req_wdata[2];
        end else if (rise) begin
          m_halt = 1'b0; m_res = 1'b0;
        end
      end
      m_pulse = rise;
      m_gen = gen_step(m_gen);
    end
  end

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Registered outputs compared against the model every cycle (R1, R4, R5, R6, R7, R8, R10)
  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      chk("R4/R5 authenticated", authenticated, m_auth);
      chk("R7/R10 dm_active", dm_active, m_act);
      chk("R7/R10 halt_req", halt_req, m_halt);
      chk("R7/R10 resume_req", resume_req, m_res);
      chk("R8 mod_rst", mod_rst, m_pulse);
      chk("R6 open authenticated", auth_open, 1);
    end
  end

  task automatic do_wr(input logic [6:0] a, input logic [31:0] d,
                       input bit exp_err, input bit exp_fwd, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    #1;
    chk({req, " wr_err"}, wr_err, exp_err);
    chk({req, " fwd_we"}, fwd_we, exp_fwd);
    @(posedge clk);
    #1 req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic do_rd(input logic [6:0] a, input longint unsigned exp, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #1;
    chk(req, rd_data, exp);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  initial begin : watchdog
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [31:0] ch;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 authenticated", authenticated, 0);
    chk("R1 mod_rst", mod_rst, 0);
    chk("R1 halt_req", halt_req, 0);
    do_rd(A_AUTH, SEED, "R1 challenge at reset");
    do_rd(A_STAT, 2, "R3 status locked");
    do_rd(A_CTRL, 0, "R1 ctrl at reset");
    do_rd(A_OTHER, 32'hCAFE_1234, "R3 pass-through read");
    // R2 locked writes
    do_wr(A_OTHER, 32'h1111, 1, 0, "R2 locked other");
    do_wr(A_STAT, 32'h3, 1, 0, "R2 locked status");
    // R7/R8 locked control write with activate edge
    do_wr(A_CTRL, 32'h7, 0, 0, "R7 locked ctrl");
    do_rd(A_CTRL, 1, "R7 only active set");
    // R5 wrong answer
    do_wr(A_AUTH, 32'h0, 0, 0, "R5 wrong answer");
    do_rd(A_AUTH, m_chal, "R5 new challenge");
    chk("R5 challenge moved", m_chal != SEED, 1);
    // R4 correct answer
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = A_AUTH;
    #1 ch = rd_data;
    @(posedge clk);
    #1 req_valid = 1'b0;
    do_wr(A_AUTH, ch + KEY, 0, 0, "R4 correct answer");
    do_rd(A_STAT, 3, "R3 status open");
    // R2 open writes
    do_wr(A_OTHER, 32'h2222, 0, 1, "R2 open other");
    do_wr(A_STAT, 32'h0, 0, 0, "R2 open status no forward");
    // R10 authenticated control writes
    do_wr(A_CTRL, 32'h3, 0, 0, "R10 halt");
    do_rd(A_CTRL, 3, "R10 ctrl readback");
    do_wr(A_CTRL, 32'h6, 0, 0, "R10 deactivate");
    do_wr(A_CTRL, 32'h5, 0, 0, "R8 R10 activate resume");
    do_wr(A_CTRL, 32'h3, 0, 0, "R10 halt again");
    // Relock, then locked control writes must keep halt
    do_wr(A_AUTH, 32'h1234_5678, 0, 0, "R5 relock");
    do_rd(A_AUTH, m_chal, "R5 relock challenge");
    do_wr(A_OTHER, 32'h3333, 1, 0, "R2 relocked other");
    do_wr(A_CTRL, 32'h1, 0, 0, "R7 locked keep halt");
    chk("R7 halt kept", halt_req, 1);
    do_wr(A_CTRL, 32'h0, 0, 0, "R7 locked deactivate");
    chk("R7 halt kept after deactivate", halt_req, 1);
    // R6 open instance
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = A_AUTH; req_wdata = 32'hDEAD;
    #1 chk("R6 open auth write no error", wr_err_open, 0);
    @(posedge clk);
    #1 req_write = 1'b0;
    @(negedge clk);
    #1 chk("R6 open challenge unchanged", rd_open, SEED);
    req_addr = A_STAT;
    #1 chk("R6 R3 open status", rd_open, 1);
    req_write = 1'b1; req_addr = A_OTHER;
    #1 chk("R6 R2 open forward", fwd_we_open, 1);
    @(posedge clk);
    #1 req_valid = 1'b0; req_write = 1'b0;
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule